// File: doc/BRIEF.md
# Exception and Status Control Unit

This block keeps the system-control state of a small 32-bit RISC core. That state is a mode stack of kernel/user and interrupt-enable pairs, an interrupt mask, a set of latched pending-interrupt bits, the last exception code, the exception return address and the faulting data address. The pipeline presents an exception request with a four-bit code, the PC of the faulting instruction and the address that caused it. The unit accepts the request, updates its registers and raises a one-cycle redirect to a fixed handler vector. A return-from-exception strobe unwinds the mode stack.

External interrupt lines are latched into pending bits. When the current interrupt-enable bit is set and a pending bit has its mask bit set, the unit raises an interrupt request and takes it by itself as an exception with code 0. Register move instructions reach the registers through a register-number port. Reads are combinational and writes take effect at the next clock edge.

A two-state machine orders the work. State ST_RUN accepts traps. The transition RUN-to-REDIR is taken when a trap is accepted. State ST_REDIR drives the redirect for one cycle and ignores new requests. The transition REDIR-to-RUN is always taken on the next edge.

Top module: `sysctl_unit`

## Requirements
- R1: After reset, every mapped register reads 0 and both redirect_o and irq_req_o are 0.
- R2: Status bits 5:0 hold three pairs, each with interrupt-enable in the even bit and kernel/user in the odd bit, where user mode is 1. The current pair is bits 1:0, the previous pair is bits 3:2 and the old pair is bits 5:4. Accepting a trap shifts these six bits left by two and clears the current pair.
- R3: On the edge that accepts a trap, EPC takes exc_pc_i and Cause bits 5:2 take the code. In the following cycle redirect_o is 1 for exactly one cycle and redirect_pc_o is 0x80000080.
- R4: BadVAddr takes exc_addr_i only for code 4 (load or fetch address error) or code 5 (store address error). Other codes leave it unchanged.
- R5: A return strobe copies the previous pair into the current pair and the old pair into the previous pair, and leaves the old pair unchanged.
- R6: Interrupt line i sets Cause bit 8+i. The bit stays set after the line falls and is cleared or set only by a Cause write to that field. A line that is high wins over a write.
- R7: irq_req_o is 1 only when Status bit 0 is 1 and some pending bit i has Status mask bit 8+i set.
- R8: A pending interrupt request in ST_RUN is taken as a trap with code 0. An explicit exception request in the same cycle wins.
- R9: Exception and interrupt requests made during the redirect cycle are ignored.
- R10: Register numbers are 8 for BadVAddr (read-only), 12 for Status, 13 for Cause and 14 for EPC. Any other number reads 0. Unimplemented bits read 0, and the Cause code field ignores writes.
- R11: In a cycle that accepts a trap, the return strobe and register writes are ignored. In a cycle with a return strobe, register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid_i | input | 1 | Exception request |
| exc_code_i | input | 4 | Exception cause code |
| exc_pc_i | input | 32 | PC of the faulting or currently issuing instruction |
| exc_addr_i | input | 32 | Faulting data address |
| rfe_i | input | 1 | Return-from-exception strobe |
| irq_lines_i | input | NIRQ | External interrupt lines |
| cp_addr_i | input | 5 | Register number for moves |
| cp_we_i | input | 1 | Register write enable |
| cp_wdata_i | input | 32 | Register write data |
| cp_rdata_o | output | 32 | Register read data (combinational) |
| irq_req_o | output | 1 | Enabled interrupt pending |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 32 | Handler vector |

## Verification
Register writes, pending-bit latching and trap state updates appear on cp_rdata_o in the cycle after the edge that caused them. The redirect pulse is also due in the cycle after the accepting edge, and irq_req_o follows combinationally from the registered state. An interrupt line raised in one cycle therefore makes the request visible one cycle later, and the redirect follows one cycle after that. The bench drives each stimulus just after a rising edge and queues the expected value for the cycle in which it is due. A monitor compares the outputs on the falling edge of that same cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_REDIR = 1'b1
    } trap_st_e;

    // cause codes
    localparam logic [3:0] XC_IRQ     = 4'd0;
    localparam logic [3:0] XC_ADDR_LD = 4'd4;
    localparam logic [3:0] XC_ADDR_ST = 4'd5;
    localparam logic [3:0] XC_IBUS    = 4'd6;
    localparam logic [3:0] XC_DBUS    = 4'd7;
    localparam logic [3:0] XC_SYS     = 4'd8;
    localparam logic [3:0] XC_BRK     = 4'd9;
    localparam logic [3:0] XC_RSVD    = 4'd10;
    localparam logic [3:0] XC_OVF     = 4'd12;

    // register numbers
    localparam logic [4:0] RN_FAULTADDR = 5'd8;
    localparam logic [4:0] RN_STATUS    = 5'd12;
    localparam logic [4:0] RN_CAUSE     = 5'd13;
    localparam logic [4:0] RN_RETPC     = 5'd14;

    // field positions
    localparam int CODE_LSB  = 2;
    localparam int FIELD_LSB = 8;
    localparam int STK_PAIRS = 3;

endpackage

// File: rtl/sc_mode_stack.sv
module sc_mode_stack #(
    parameter int PAIRS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              we_i,
    input  logic [2*PAIRS-1:0] wdata_i,
    output logic [2*PAIRS-1:0] stk_o
);
    localparam int SW = 2 * PAIRS;

    logic [SW-1:0] stk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_q <= '0;
        end else if (push_i) begin
            stk_q <= {stk_q[SW-3:0], 2'b00};
        end else if (pop_i) begin
            stk_q <= {stk_q[SW-1 -: 2], stk_q[SW-1:2]};
        end else if (we_i) begin
            stk_q <= wdata_i;
        end
    end

    assign stk_o = stk_q;

endmodule

// File: rtl/sc_pend_reg.sv
module sc_pend_reg #(
    parameter int NIRQ = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] lines_i,
    input  logic            we_i,
    input  logic [NIRQ-1:0] wdata_i,
    output logic [NIRQ-1:0] pend_o
);
    logic [NIRQ-1:0] pend_q;

    for (genvar i = 0; i < NIRQ; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
            end else if (lines_i[i]) begin
                pend_q[i] <= 1'b1;
            end else if (we_i) begin
                pend_q[i] <= wdata_i[i];
            end
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/sc_trap_fsm.sv
module sc_trap_fsm
    import sysctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exc_valid_i,
    input  logic irq_req_i,
    output logic take_o,
    output logic take_irq_o,
    output logic redirect_o
);
    trap_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:   if (exc_valid_i || irq_req_i) st_d = ST_REDIR;
            ST_REDIR: st_d = ST_RUN;
            default:  st_d = ST_RUN;
        endcase
    end

    always_comb begin
        take_o     = 1'b0;
        take_irq_o = 1'b0;
        redirect_o = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                take_o     = exc_valid_i || irq_req_i;
                take_irq_o = !exc_valid_i && irq_req_i;
            end
            ST_REDIR: redirect_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sysctl_unit.sv
module sysctl_unit
    import sysctl_pkg::*;
#(
    parameter int          NIRQ   = 5,
    parameter int          XLEN   = 32,
    parameter logic [31:0] VECTOR = 32'h8000_0080
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exc_valid_i,
    input  logic [3:0]      exc_code_i,
    input  logic [XLEN-1:0] exc_pc_i,
    input  logic [XLEN-1:0] exc_addr_i,
    input  logic            rfe_i,
    input  logic [NIRQ-1:0] irq_lines_i,
    input  logic [4:0]      cp_addr_i,
    input  logic            cp_we_i,
    input  logic [XLEN-1:0] cp_wdata_i,
    output logic [XLEN-1:0] cp_rdata_o,
    output logic            irq_req_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o
);
    localparam int SW = 2 * STK_PAIRS;

    logic            take, take_irq, rfe_fire, wr_fire;
    logic [SW-1:0]   stk;
    logic [NIRQ-1:0] pend, mask_q;
    logic [3:0]      code_q;
    logic [XLEN-1:0] epc_q, badv_q;
    logic            wr_status, wr_cause, wr_epc;

    assign rfe_fire  = rfe_i && !take;
    assign wr_fire   = cp_we_i && !take && !rfe_i;
    assign wr_status = wr_fire && (cp_addr_i == RN_STATUS);
    assign wr_cause  = wr_fire && (cp_addr_i == RN_CAUSE);
    assign wr_epc    = wr_fire && (cp_addr_i == RN_RETPC);

    sc_trap_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_valid_i(exc_valid_i),
        .irq_req_i  (irq_req_o),
        .take_o     (take),
        .take_irq_o (take_irq),
        .redirect_o (redirect_o)
    );

    sc_mode_stack #(.PAIRS(STK_PAIRS)) u_stk (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (take),
        .pop_i  (rfe_fire),
        .we_i   (wr_status),
        .wdata_i(cp_wdata_i[SW-1:0]),
        .stk_o  (stk)
    );

    sc_pend_reg #(.NIRQ(NIRQ)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .lines_i(irq_lines_i),
        .we_i   (wr_cause),
        .wdata_i(cp_wdata_i[FIELD_LSB +: NIRQ]),
        .pend_o (pend)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            code_q <= '0;
            epc_q  <= '0;
            badv_q <= '0;
        end else begin
            if (wr_status) mask_q <= cp_wdata_i[FIELD_LSB +: NIRQ];
            if (take) begin
                code_q <= take_irq ? XC_IRQ : exc_code_i;
                epc_q  <= exc_pc_i;
                if (!take_irq && (exc_code_i == XC_ADDR_LD || exc_code_i == XC_ADDR_ST))
                    badv_q <= exc_addr_i;
            end else if (wr_epc) begin
                epc_q <= cp_wdata_i;
            end
        end
    end

    assign irq_req_o     = stk[0] && |(pend & mask_q);
    assign redirect_pc_o = VECTOR[XLEN-1:0];

    logic [XLEN-1:0] status_rd, cause_rd;

    always_comb begin
        status_rd = '0;
        status_rd[SW-1:0] = stk;
        status_rd[FIELD_LSB +: NIRQ] = mask_q;
        cause_rd = '0;
        cause_rd[CODE_LSB +: 4] = code_q;
        cause_rd[FIELD_LSB +: NIRQ] = pend;
    end

    always_comb begin
        unique case (cp_addr_i)
            RN_FAULTADDR: cp_rdata_o = badv_q;
            RN_STATUS:    cp_rdata_o = status_rd;
            RN_CAUSE:     cp_rdata_o = cause_rd;
            RN_RETPC:     cp_rdata_o = epc_q;
            default:      cp_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/sysctl_unit_chk.sv
module sysctl_unit_chk #(
    parameter int NIRQ = 5,
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take,
    input logic            rfe_fire,
    input logic            redirect_o,
    input logic            irq_req_o,
    input logic [5:0]      stk,
    input logic [NIRQ-1:0] pend,
    input logic [NIRQ-1:0] irq_lines_i,
    input logic [XLEN-1:0] epc_q,
    input logic            wr_epc
);
    // R2
    stack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (stk[1:0] == 2'b00) && (stk[5:2] == $past(stk[3:0])));

    // R5
    stack_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfe_fire |=> (stk[5:4] == $past(stk[5:4])) && (stk[3:2] == $past(stk[5:4]))
                     && (stk[1:0] == $past(stk[3:2])));

    // R3
    redirect_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> redirect_o);

    // R3
    redirect_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);

    // R7
    irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> stk[0]);

    // R6
    pend_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lines_i != '0) |=> ((pend & $past(irq_lines_i)) == $past(irq_lines_i)));

    // R9
    redirect_hold_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && !wr_epc) |=> $stable(epc_q));

endmodule

bind sysctl_unit sysctl_unit_chk #(.NIRQ(NIRQ), .XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .rfe_fire   (rfe_fire),
    .redirect_o (redirect_o),
    .irq_req_o  (irq_req_o),
    .stk        (stk),
    .pend       (pend),
    .irq_lines_i(irq_lines_i),
    .epc_q      (epc_q),
    .wr_epc     (wr_epc)
);

// File: tb/sysctl_unit_tb.sv
module sysctl_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid_i = 1'b0;
    logic [3:0]  exc_code_i = '0;
    logic [31:0] exc_pc_i = '0;
    logic [31:0] exc_addr_i = '0;
    logic        rfe_i = 1'b0;
    logic [NIRQ-1:0] irq_lines_i = '0;
    logic [4:0]  cp_addr_i = '0;
    logic        cp_we_i = 1'b0;
    logic [31:0] cp_wdata_i = '0;
    logic [31:0] cp_rdata_o;
    logic        irq_req_o, redirect_o;
    logic [31:0] redirect_pc_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_unit #(.NIRQ(NIRQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
        .exc_pc_i(exc_pc_i), .exc_addr_i(exc_addr_i), .rfe_i(rfe_i),
        .irq_lines_i(irq_lines_i), .cp_addr_i(cp_addr_i), .cp_we_i(cp_we_i),
        .cp_wdata_i(cp_wdata_i), .cp_rdata_o(cp_rdata_o), .irq_req_o(irq_req_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
    );

    // kind: 0 read data, 1 redirect, 2 irq request, 3 redirect target
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb[$];

    task automatic expect_out(input int kind, input logic [31:0] exp, input string tag);
        exp_t e;
        e.kind = kind; e.exp = exp; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares all items queued for the current cycle
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            logic [31:0] act;
            e = sb.pop_front();
            case (e.kind)
                0: act = cp_rdata_o;
                1: act = {31'b0, redirect_o};
                2: act = {31'b0, irq_req_o};
                default: act = redirect_pc_o;
            endcase
            checks++;
            if (act !== e.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", e.tag, act, e.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        exc_valid_i = 1'b0;
        rfe_i = 1'b0;
        cp_we_i = 1'b0;
        irq_lines_i = '0;
    endtask

    task automatic chk_reg(input logic [4:0] a, input logic [31:0] exp, input string tag);
        tick();
        cp_addr_i = a;
        expect_out(0, exp, tag);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        tick();
        cp_addr_i = a; cp_we_i = 1'b1; cp_wdata_i = d;
    endtask

    task automatic raise(input logic [3:0] c, input logic [31:0] pc, input logic [31:0] ad);
        exc_valid_i = 1'b1; exc_code_i = c; exc_pc_i = pc; exc_addr_i = ad;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        chk_reg(5'd12, 32'h0, "R1 status");
        expect_out(1, 0, "R1 redirect");
        expect_out(2, 0, "R1 irq");
        chk_reg(5'd13, 32'h0, "R1 cause");
        chk_reg(5'd14, 32'h0, "R1 epc");
        chk_reg(5'd8,  32'h0, "R1 badvaddr");

        // R10 unimplemented mask bits read zero
        wr_reg(5'd12, 32'h0000_FF3F);
        chk_reg(5'd12, 32'h0000_1F3F, "R10 status field width");
        wr_reg(5'd12, 32'h0000_000B);
        chk_reg(5'd12, 32'h0000_000B, "R10 status write");

        // R2/R3/R4 reserved-instruction trap
        tick(); raise(4'd10, 32'h0040_0010, 32'h0000_DEAD);
        tick();
        expect_out(1, 1, "R3 redirect pulse");
        expect_out(3, 32'h8000_0080, "R3 vector");
        cp_addr_i = 5'd12; expect_out(0, 32'h2C, "R2 push");
        chk_reg(5'd13, 32'h28, "R3 code");
        expect_out(1, 0, "R3 redirect one cycle");
        chk_reg(5'd14, 32'h0040_0010, "R3 epc");
        chk_reg(5'd8, 32'h0, "R4 badvaddr untouched");

        // R4/R9 address error, then a request during redirect
        tick(); raise(4'd4, 32'h0000_0500, 32'h1234_5677);
        tick(); raise(4'd9, 32'h0000_0999, 32'h0);
        expect_out(1, 1, "R9 redirect");
        tick(); expect_out(1, 0, "R9 no second redirect");
        cp_addr_i = 5'd13; expect_out(0, 32'h10, "R9 code kept");
        chk_reg(5'd14, 32'h0000_0500, "R9 epc kept");
        chk_reg(5'd8, 32'h1234_5677, "R4 badvaddr captured");
        chk_reg(5'd12, 32'h30, "R2 second push");

        // R5 return
        tick(); rfe_i = 1'b1;
        chk_reg(5'd12, 32'h3C, "R5 pop");
        tick(); rfe_i = 1'b1;
        chk_reg(5'd12, 32'h3F, "R5 second pop");

        // R10 read-only / unmapped
        wr_reg(5'd8, 32'h0000_FFFF);
        chk_reg(5'd8, 32'h1234_5677, "R10 badvaddr read-only");
        wr_reg(5'd13, 32'h0000_003C);
        chk_reg(5'd13, 32'h10, "R10 code unwritable");
        chk_reg(5'd3, 32'h0, "R10 unmapped");
        wr_reg(5'd14, 32'hABCD_0000);
        chk_reg(5'd14, 32'hABCD_0000, "R10 epc write");

        // R6/R7 pending latch with mask closed
        tick(); irq_lines_i = 5'b00100;
        tick(); cp_addr_i = 5'd13;
        expect_out(0, 32'h410, "R6 pending latched");
        expect_out(2, 0, "R7 masked");
        // R7/R8 open mask: auto interrupt
        wr_reg(5'd12, 32'h0000_043F);
        tick(); exc_pc_i = 32'h0000_0700;
        expect_out(2, 1, "R7 irq request");
        tick();
        expect_out(1, 1, "R8 irq redirect");
        expect_out(2, 0, "R7 ie cleared");
        cp_addr_i = 5'd12; expect_out(0, 32'h43C, "R8 push");
        chk_reg(5'd13, 32'h400, "R8 code zero");
        chk_reg(5'd14, 32'h0000_0700, "R8 epc");

        // R6 software clear
        wr_reg(5'd13, 32'h0);
        chk_reg(5'd13, 32'h0, "R6 cleared");

        // R8 explicit exception beats interrupt
        wr_reg(5'd13, 32'h0000_0400);
        tick(); rfe_i = 1'b1;
        tick(); raise(4'd8, 32'h0000_0800, 32'h0);
        expect_out(2, 1, "R8 irq also pending");
        tick(); expect_out(1, 1, "R8 redirect");
        cp_addr_i = 5'd13; expect_out(0, 32'h420, "R8 explicit wins");
        chk_reg(5'd14, 32'h0000_0800, "R8 epc explicit");
        chk_reg(5'd12, 32'h43C, "R8 status");

        // R11 priorities
        wr_reg(5'd13, 32'h0);
        tick(); rfe_i = 1'b1; cp_we_i = 1'b1; cp_addr_i = 5'd12; cp_wdata_i = 32'h0;
        chk_reg(5'd12, 32'h43F, "R11 rfe beats write");
        tick(); raise(4'd12, 32'h0000_0900, 32'h0);
        rfe_i = 1'b1; cp_we_i = 1'b1; cp_addr_i = 5'd14; cp_wdata_i = 32'h1111;
        tick(); expect_out(1, 1, "R11 redirect");
        expect_out(0, 32'h0000_0900, "R11 trap beats write");
        chk_reg(5'd12, 32'h43C, "R11 trap beats rfe");
        chk_reg(5'd13, 32'h30, "R11 overflow code");

        tick();
        tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule